// File: doc/BRIEF.md
# Upper-Memory Shadow Access Router

This block sorts every memory cycle that falls in the C0000h-FFFFFh window into one of three destinations: local DRAM holding shadowed code, the boot ROM chip select, or the expansion bus. Each cycle comes in with its address, a read/write flag and a one-cycle valid strobe. The router looks at the shadow control fields and drives one registered select in the next cycle. A write that protection refuses drives no select. Instead it raises a one-cycle blocked flag.

Reads and writes to the same address can be routed differently. In the top 64KB, reads can come from ROM while writes fill DRAM. In the C0000h area, copy mode reads from the expansion bus while writes land in shadow RAM. Together these let firmware copy ROM images into DRAM and then write-protect them.

Each of the C, D and E 64KB areas has four 16KB segments, and each segment has its own enable bit. The segment is chosen by address bits [15:14], so bit n of an enable vector covers the segment at offset n*16KB.

Top module: `shadow_route`

## Requirements
- R1: A cycle whose address is outside C0000h-FFFFFh, including any address at or above 1MB, drives no select and no blocked flag.
- R2: In the C, D or E area, a cycle to a segment whose enable bit is clear goes to the expansion bus for both reads and writes. For the E area this applies only while `e_area_on` is set.
- R3: In the D or E area, a shadowed segment returns reads from DRAM. A write goes to DRAM when that area's write-protect bit is clear. When the bit is set, the write is blocked.
- R4: In the C area, a shadowed segment follows `c_copy`. When `c_copy` is set, reads go to the expansion bus. When it is clear, reads come from DRAM. In both cases writes go to DRAM, unless `wp_c` blocks them.
- R5: While `e_area_on` is clear, E-area reads assert the ROM chip select and E-area writes go to the expansion bus, whatever the segment enables say.
- R6: In F0000h-FFFFFh with `f_rom_read` set, reads assert the ROM chip select and writes go to DRAM. The ROM chip select is never asserted for a write.
- R7: In F0000h-FFFFFh with `f_rom_read` clear, reads come from DRAM and every write is blocked.
- R8: Outputs appear in the cycle after the strobe and last exactly one cycle. At most one of the four outputs is high at a time, and all of them are low in a cycle that follows no strobe.
- R9: During reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_vld | input | 1 | One-cycle memory cycle strobe |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| cyc_addr | input | ADDR_W | Byte address of the cycle |
| shd_c_en | input | SEGS | Per-16KB shadow enables, C area |
| shd_d_en | input | SEGS | Per-16KB shadow enables, D area |
| shd_e_en | input | SEGS | Per-16KB shadow enables, E area |
| e_area_on | input | 1 | E area shadowing on; when clear, reads use the ROM |
| wp_c | input | 1 | Write protect, C area |
| wp_d | input | 1 | Write protect, D area |
| wp_e | input | 1 | Write protect, E area |
| c_copy | input | 1 | C area copy mode |
| f_rom_read | input | 1 | Top 64KB: reads from ROM, writes to DRAM |
| dram_sel | output | 1 | Cycle goes to local DRAM |
| rom_cs | output | 1 | Boot ROM chip select |
| bus_sel | output | 1 | Cycle goes to the expansion bus |
| wr_blocked | output | 1 | Write refused by protection |

## Verification
The sweep pairs each segment's own enable with the inverse value on its three neighbours. A design that indexed the segment with the wrong address bits would then route to the wrong destination. Addresses just below C0000h and above 1MB are included to catch decoding that ignores the upper address bits. Every combination of write protect, copy mode, E-area mode and top-64KB mode is crossed with both directions. That exposes a design that drove the ROM select on a write or that let a protected write reach DRAM. Idle cycles between and after strobes check that no output outlives its one cycle.

// File: rtl/shadow_route.sv
module shadow_route #(
  parameter int ADDR_W = 24,
  parameter int SEGS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_vld,
  input  logic              cyc_wr,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [SEGS-1:0]   shd_c_en,
  input  logic [SEGS-1:0]   shd_d_en,
  input  logic [SEGS-1:0]   shd_e_en,
  input  logic              e_area_on,
  input  logic              wp_c,
  input  logic              wp_d,
  input  logic              wp_e,
  input  logic              c_copy,
  input  logic              f_rom_read,
  output logic              dram_sel,
  output logic              rom_cs,
  output logic              bus_sel,
  output logic              wr_blocked
);
  localparam int SEG_IW = $clog2(SEGS);

  logic              upper;
  logic [1:0]        area;
  logic [SEG_IW-1:0] seg;
  logic              to_dram, to_rom, to_bus, blk;

  assign upper = (cyc_addr[ADDR_W-1:20] == '0) && (cyc_addr[19:18] == 2'b11);
  assign area  = cyc_addr[17:16];
  assign seg   = cyc_addr[15 -: SEG_IW];

  always_comb begin
    to_dram = 1'b0;
    to_rom  = 1'b0;
    to_bus  = 1'b0;
    blk     = 1'b0;
    if (cyc_vld && upper) begin
      unique case (area)
        2'd0: begin
          if (!shd_c_en[seg])  to_bus = 1'b1;
          else if (!cyc_wr)    begin to_bus = c_copy; to_dram = !c_copy; end
          else                 begin blk = wp_c; to_dram = !wp_c; end
        end
        2'd1: begin
          if (!shd_d_en[seg])  to_bus = 1'b1;
          else if (!cyc_wr)    to_dram = 1'b1;
          else                 begin blk = wp_d; to_dram = !wp_d; end
        end
        2'd2: begin
          if (!e_area_on)      begin to_rom = !cyc_wr; to_bus = cyc_wr; end
          else if (!shd_e_en[seg]) to_bus = 1'b1;
          else if (!cyc_wr)    to_dram = 1'b1;
          else                 begin blk = wp_e; to_dram = !wp_e; end
        end
        default: begin
          if (f_rom_read)      begin to_rom = !cyc_wr; to_dram = cyc_wr; end
          else                 begin blk = cyc_wr; to_dram = !cyc_wr; end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_sel   <= 1'b0;
      rom_cs     <= 1'b0;
      bus_sel    <= 1'b0;
      wr_blocked <= 1'b0;
    end else begin
      dram_sel   <= to_dram;
      rom_cs     <= to_rom;
      bus_sel    <= to_bus;
      wr_blocked <= blk;
    end
  end
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_vld,
  input logic              cyc_wr,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic              dram_sel,
  input logic              rom_cs,
  input logic              bus_sel,
  input logic              wr_blocked
);
  logic any_out;
  assign any_out = dram_sel | rom_cs | bus_sel | wr_blocked;

  a_r8_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_sel, rom_cs, bus_sel, wr_blocked}));

  a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(cyc_vld));

  a_r6_rom_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> !$past(cyc_wr));

  a_r3_block_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> $past(cyc_wr));

  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && !(cyc_addr >= ADDR_W'(20'hC0000) && cyc_addr <= ADDR_W'(20'hFFFFF)))
      |=> !any_out);
endmodule

bind shadow_route shadow_route_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_wr(cyc_wr),
  .cyc_addr(cyc_addr), .dram_sel(dram_sel), .rom_cs(rom_cs),
  .bus_sel(bus_sel), .wr_blocked(wr_blocked));

// File: tb/shadow_route_tb.sv
module shadow_route_tb;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cyc_vld = 1'b0;
  logic              cyc_wr = 1'b0;
  logic [ADDR_W-1:0] cyc_addr = '0;
  logic [3:0]        shd_c_en = '0, shd_d_en = '0, shd_e_en = '0;
  logic              e_area_on = 1'b0, wp_c = 1'b0, wp_d = 1'b0, wp_e = 1'b0;
  logic              c_copy = 1'b0, f_rom_read = 1'b0;
  logic              dram_sel, rom_cs, bus_sel, wr_blocked;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shadow_route #(.ADDR_W(ADDR_W), .SEGS(4)) u_dut (.*);

  // 0 none, 1 dram, 2 rom, 3 bus, 4 blocked
  function automatic int expect_dest(input int reg_hi, input bit seg_on, input bit wr,
                                     input bit wp, input bit cp, input bit ea, input bit fr);
    if (reg_hi < 'hC || reg_hi > 'hF) return 0;                    // R1
    case (reg_hi)
      'hC: if (!seg_on) return 3; else if (!wr) return cp ? 3 : 1;  // R2 R4
           else return wp ? 4 : 1;
      'hD: if (!seg_on) return 3; else if (!wr) return 1;           // R2 R3
           else return wp ? 4 : 1;
      'hE: if (!ea) return wr ? 3 : 2;                              // R5
           else if (!seg_on) return 3; else if (!wr) return 1;
           else return wp ? 4 : 1;
      default: if (fr) return wr ? 1 : 2;                           // R6
               else return wr ? 4 : 1;                              // R7
    endcase
  endfunction

  task automatic check_out(input string req, input int exp_code);
    logic [3:0] got, want;
    got = {wr_blocked, bus_sel, rom_cs, dram_sel};
    want = (exp_code == 0) ? 4'b0000 : 4'(1 << (exp_code - 1));
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s addr=%h wr=%b got=%b expected=%b", req, cyc_addr, cyc_wr, got, want);
    end
  endtask

  initial begin
    int regs[6] = '{'hB, 'hC, 'hD, 'hE, 'hF, 'h1C};
    repeat (3) @(negedge clk);
    check_out("R9", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R8 idle", 0);
    foreach (regs[ri]) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          for (int cfg = 0; cfg < 32; cfg++) begin
            bit sb, wp, cp, ea, fr;
            int e;
            {sb, wp, cp, ea, fr} = 5'(cfg);
            shd_c_en = sb ? 4'(1 << s) : ~4'(1 << s);
            shd_d_en = shd_c_en;
            shd_e_en = shd_c_en;
            wp_c = wp; wp_d = wp; wp_e = wp;
            c_copy = cp; e_area_on = ea; f_rom_read = fr;
            cyc_addr = ADDR_W'((regs[ri] << 16) | (s << 14) | (cfg * 'h13 + w));
            cyc_wr = w[0];
            cyc_vld = 1'b1;
            e = expect_dest(regs[ri], sb, w[0], wp, cp, ea, fr);
            @(negedge clk);
            cyc_vld = 1'b0;
            check_out("R1-route R2 R3 R4 R5 R6 R7", e);
            if (cfg == 7) begin
              @(negedge clk);
              check_out("R8 one-cycle", 0);
            end
          end
        end
      end
    end
    @(negedge clk);
    check_out("R8 idle end", 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule